// File: doc/BRIEF.md
# Real-Time Counter with Match Wake-Up

This block keeps long-interval time from a slow crystal. Each crystal rising edge arrives as a one-cycle strobe in the host clock domain. A 7-bit prescaler divides those strobes by 128. At 32.768 kHz this advances a 40-bit up-counter every 3.90625 ms. A match value of 0xE1000 therefore spans one hour.

A 40-bit match register is compared with the counter at all times. When the two are equal, the block can drive two identical wake-up outputs. It can also return the counter to zero on the next counter step.

A host reaches everything through a byte-wide register port. The port covers one control byte, five counter bytes and five match bytes. Two oscillator-setup fields in the control byte are not used inside the block. They only drive output pins.

Top module: `rtc_match_timer`

Register addresses:
- 0: control.
- 1 to 5: counter, least significant byte first.
- 6 to 10: match, least significant byte first.
- Any other address reads 0.

Read timing: read data appears on `bus_rdata` one clock after a cycle with `bus_rd` high. It holds until the next read.

Control bits:

| Bit | Function |
|---|---|
| 7 | Soft reset |
| 6 | Run |
| 5 | Match-output enable |
| 4:3 | Oscillator mode |
| 2 | Clear on match |
| 1 | Counter keep, active low clear |
| 0 | Oscillator select |

## Requirements
- R1: After reset the control byte reads 0x80, the counter and match registers read 0, and both match outputs are 0.
- R2: Starting from a stopped state, the first counter increment comes on the 64th crystal strobe after counting becomes possible. Later increments come every 128 strobes.
- R3: The counter advances only when all three of these hold: bit 6 is 1, bit 1 is 1, and soft reset is released. Clearing bit 6 freezes the counter at its current value.
- R4: While bit 7 is 1, the counter and prescaler are held at zero. After bit 7 is written back to 0, strobes in the next two clock cycles are ignored.
- R5: A host write to a counter byte (addresses 1 to 5) changes the counter only while bit 6 is 0. Otherwise it is dropped.
- R6: Both match outputs are 1 exactly when bit 5 is 1 and the counter equals the match register.
- R7: With bit 2 set, a counter step taken while the counter equals a nonzero match value loads 0 instead of incrementing. A match value of zero never causes this clear.
- R8: While bit 1 is 0, the counter is held at 0.
- R9: `xtal_mode` follows control bits 4:3 and `xtal_sel` follows control bit 0.
- R10: Reading address 1 returns the live low byte and captures the upper 32 bits. Reads of addresses 2 to 5 return the captured bytes.
- R11: Without clear on match, the counter steps from all ones to 0.
- R12: Match bytes at addresses 6 to 10 are writable at any time and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xtal_pulse | input | 1 | One-cycle strobe per crystal rising edge |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one clock after `bus_rd` |
| match_irq | output | 1 | Match indication |
| match_wake | output | 1 | Match wake-up for power control |
| xtal_mode | output | 2 | Oscillator mode field |
| xtal_sel | output | 1 | Oscillator select bit |

## Verification
The hard states to reach are the counter sitting on an hour-scale match value and the counter at all ones just before it wraps. Natural counting would need millions of strobes to get there. The bench stops the counter and preloads it one step short of the target. It then re-enables counting and supplies exactly 64 strobes, so it also checks the half-period first step.

The two-cycle soft-reset release is reached another way. Strobes are driven back to back from the cycle right after the releasing write. The bench then counts how many of them the prescaler actually absorbed.

// File: rtl/rtc_match_pkg.sv
package rtc_match_pkg;

  typedef struct packed {
    logic       srst;
    logic       run;
    logic       match_en;
    logic [1:0] xmode;
    logic       clr_match;
    logic       cnt_rn;
    logic       xtal_en;
  } rtc_ctl_t;

  localparam logic [7:0] CTL_RESET = 8'h80;
  localparam int ADDR_CTL  = 0;
  localparam int ADDR_CNT0 = 1;

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRE_W = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic pulse,
  output logic tick
);
  localparam logic [PRE_W-1:0] HALF = {1'b1, {(PRE_W-1){1'b0}}};

  logic [PRE_W-1:0] pre_q, pre_d;

  always_comb begin
    pre_d = pre_q;
    if (!run)       pre_d = HALF;
    else if (pulse) pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= HALF;
    else        pre_q <= pre_d;
  end

  assign tick = run & pulse & (&pre_q);

  // R2: counting restarts from the half-period point
  assert_half_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (pre_q == HALF));

  assert_tick_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_match_pkg::*;
#(
  parameter int CNT_W    = 40,
  parameter int ADDR_W   = 4,
  parameter int MAT_BASE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output rtc_ctl_t          ctl_q,
  output logic [CNT_W-1:0]  match_q,
  output logic              srst
);
  localparam int NB = CNT_W / 8;

  rtc_ctl_t         ctl_d;
  logic [CNT_W-1:0] match_d;
  logic [1:0]       rel_q, rel_d;

  always_comb begin
    ctl_d   = ctl_q;
    match_d = match_q;
    rel_d   = {rel_q[0], ctl_q.srst};
    if (wr_en) begin
      if (addr == ADDR_W'(ADDR_CTL)) ctl_d = rtc_ctl_t'(wdata);
      for (int i = 0; i < NB; i++)
        if (addr == ADDR_W'(MAT_BASE + i)) match_d[8*i +: 8] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= rtc_ctl_t'(CTL_RESET);
      match_q <= '0;
      rel_q   <= 2'b11;
    end else begin
      ctl_q   <= ctl_d;
      match_q <= match_d;
      rel_q   <= rel_d;
    end
  end

  assign srst = ctl_q.srst | (|rel_q);

  // R4: soft reset outlives the bit by two cycles
  assert_release_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q.srst) |=> srst);

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CNT_W  = 40,
  parameter int ADDR_W = 4,
  parameter int BASE   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load_ok,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              tick,
  input  logic              clr_match_en,
  input  logic [CNT_W-1:0]  match_val,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              hit
);
  localparam int NB = CNT_W / 8;

  logic [CNT_W-1:0] cnt_d;
  logic             clr_hit;

  assign hit     = (cnt_q == match_val);
  assign clr_hit = clr_match_en & hit & (|match_val);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (tick) begin
      if (clr_hit) cnt_d = '0;
      else         cnt_d = cnt_q + CNT_W'(1);
    end else if (wr_en && load_ok) begin
      for (int i = 0; i < NB; i++)
        if (addr == ADDR_W'(BASE + i)) cnt_d[8*i +: 8] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_clear_on_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && tick && clr_match_en && hit && (match_val != '0)) |=> (cnt_q == '0));

  assert_zero_match_no_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && tick && (match_val == '0) && (cnt_q == '0)) |=> (cnt_q == CNT_W'(1)));

  assert_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && tick && !clr_match_en && (&cnt_q)) |=> (cnt_q == '0));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !tick && !wr_en) |=> $stable(cnt_q));

  assert_no_load_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !tick && wr_en && !load_ok) |=> $stable(cnt_q));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_match_timer.sv
module rtc_match_timer
  import rtc_match_pkg::*;
#(
  parameter int CNT_W  = 40,
  parameter int PRE_W  = 7,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xtal_pulse,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              match_irq,
  output logic              match_wake,
  output logic [1:0]        xtal_mode,
  output logic              xtal_sel
);
  localparam int NB       = CNT_W / 8;
  localparam int MAT_BASE = ADDR_CNT0 + NB;

  logic [1:0]       rst_pipe_q;
  logic             arst_n;
  rtc_ctl_t         ctl_q;
  logic [CNT_W-1:0] match_q, cnt_q;
  logic [CNT_W-1:8] snap_q, snap_d;
  logic [7:0]       rdata_q, rdata_d;
  logic             srst, run, tick, hit, cnt_clr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign arst_n = rst_pipe_q[1];

  rtc_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .MAT_BASE(MAT_BASE)) u_regs (
    .clk(clk), .rst_n(arst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .ctl_q(ctl_q), .match_q(match_q), .srst(srst));

  assign run     = ctl_q.run & ~srst & ctl_q.cnt_rn;
  assign cnt_clr = srst | ~ctl_q.cnt_rn;

  rtc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(arst_n), .run(run), .pulse(xtal_pulse), .tick(tick));

  rtc_counter #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE(ADDR_CNT0)) u_cnt (
    .clk(clk), .rst_n(arst_n), .clr(cnt_clr), .load_ok(~ctl_q.run),
    .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .tick(tick),
    .clr_match_en(ctl_q.clr_match), .match_val(match_q), .cnt_q(cnt_q), .hit(hit));

  assign match_irq  = ctl_q.match_en & hit;
  assign match_wake = ctl_q.match_en & hit;
  assign xtal_mode  = ctl_q.xmode;
  assign xtal_sel   = ctl_q.xtal_en;

  always_comb begin
    rdata_d = rdata_q;
    snap_d  = snap_q;
    if (bus_rd) begin
      rdata_d = 8'h00;
      if (bus_addr == ADDR_W'(ADDR_CTL))  rdata_d = ctl_q;
      if (bus_addr == ADDR_W'(ADDR_CNT0)) begin
        rdata_d = cnt_q[7:0];
        snap_d  = cnt_q[CNT_W-1:8];
      end
      for (int i = 1; i < NB; i++)
        if (bus_addr == ADDR_W'(ADDR_CNT0 + i)) rdata_d = snap_q[8*i +: 8];
      for (int i = 0; i < NB; i++)
        if (bus_addr == ADDR_W'(MAT_BASE + i)) rdata_d = match_q[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rdata_q <= 8'h00;
      snap_q  <= '0;
    end else begin
      rdata_q <= rdata_d;
      snap_q  <= snap_d;
    end
  end

  assign bus_rdata = rdata_q;

  assert_match_gate_R6: assert property (@(posedge clk) disable iff (!arst_n)
    !ctl_q.match_en |-> (!match_irq && !match_wake));

  assert_soft_reset_R4: assert property (@(posedge clk) disable iff (!arst_n)
    srst |=> (cnt_q == '0));

  assert_snapshot_R10: assert property (@(posedge clk) disable iff (!arst_n)
    (bus_rd && bus_addr == ADDR_W'(ADDR_CNT0)) |=> (snap_q == $past(cnt_q[CNT_W-1:8])));

endmodule

// File: tb/sim_rtc_match_timer.sv
`timescale 1ns/1ps
module sim_rtc_match_timer;
  logic clk = 1'b0;
  logic rst_n, xtal_pulse, bus_wr, bus_rd;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic match_irq, match_wake, xtal_sel;
  logic [1:0] xtal_mode;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  rtc_match_timer u0 (.clk(clk), .rst_n(rst_n), .xtal_pulse(xtal_pulse),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .match_irq(match_irq), .match_wake(match_wake),
    .xtal_mode(xtal_mode), .xtal_sel(xtal_sel));

  task automatic check(input string tag, input logic [39:0] got, input logic [39:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // all tasks start and end at a falling clock edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      xtal_pulse = 1'b1;
      @(negedge clk);
    end
    xtal_pulse = 1'b0;
  endtask

  task automatic rd_cnt(output logic [39:0] v);
    logic [7:0] b;
    for (int i = 0; i < 5; i++) begin
      rd(4'(1 + i), b);
      v[8*i +: 8] = b;
    end
  endtask

  task automatic rd_match(output logic [39:0] v);
    logic [7:0] b;
    for (int i = 0; i < 5; i++) begin
      rd(4'(6 + i), b);
      v[8*i +: 8] = b;
    end
  endtask

  task automatic wr_cnt(input logic [39:0] v);
    for (int i = 0; i < 5; i++) wr(4'(1 + i), v[8*i +: 8]);
  endtask

  task automatic wr_match(input logic [39:0] v);
    for (int i = 0; i < 5; i++) wr(4'(6 + i), v[8*i +: 8]);
  endtask

  task automatic t_reset;
    logic [7:0] b; logic [39:0] v;
    rd(4'd0, b);     check("R1 ctl default", 40'(b), 40'h80);
    rd_cnt(v);       check("R1 counter zero", v, 40'h0);
    rd_match(v);     check("R1 match zero", v, 40'h0);
    check("R1 outputs low", 40'({match_irq, match_wake}), 40'h0);
  endtask

  task automatic t_match_reg;
    logic [39:0] v;
    wr_match(40'h01_0203_0405);
    rd_match(v);     check("R12 match readback", v, 40'h01_0203_0405);
  endtask

  task automatic t_passthru;
    logic [7:0] b;
    wr(4'd0, 8'h19);
    check("R9 xtal_mode", 40'(xtal_mode), 40'h3);
    check("R9 xtal_sel", 40'(xtal_sel), 40'h1);
    rd(4'd0, b);     check("R9 ctl readback", 40'(b), 40'h19);
  endtask

  task automatic t_prescale;
    logic [39:0] v;
    wr(4'd0, 8'h42); idle(3);
    pulses(63); rd_cnt(v); check("R2 before first step", v, 40'd0);
    pulses(1);  rd_cnt(v); check("R2 first step at 64", v, 40'd1);
    pulses(127); rd_cnt(v); check("R2 127 into period", v, 40'd1);
    pulses(1);  rd_cnt(v); check("R2 second step at 128", v, 40'd2);
  endtask

  task automatic t_hold;
    logic [39:0] v;
    wr(4'd0, 8'h02); pulses(200);
    rd_cnt(v); check("R3 frozen while stopped", v, 40'd2);
  endtask

  task automatic t_load;
    logic [39:0] v;
    wr_cnt(40'h12_3456_789A);
    rd_cnt(v); check("R5 load while stopped", v, 40'h12_3456_789A);
    wr(4'd0, 8'h42);
    wr(4'd1, 8'h00);
    rd_cnt(v); check("R5 load ignored while running", v, 40'h12_3456_789A);
  endtask

  task automatic t_keep_bit;
    logic [39:0] v;
    wr(4'd0, 8'h40); idle(2);
    rd_cnt(v); check("R8 bit1 low clears", v, 40'd0);
    idle(2); pulses(70);
    rd_cnt(v); check("R8 no count with bit1 low", v, 40'd0);
  endtask

  task automatic t_match;
    logic [39:0] v;
    wr(4'd0, 8'h02);
    wr_match(40'hE1000);
    wr_cnt(40'hE0FFF);
    wr(4'd0, 8'h62); idle(3);
    check("R6 no match yet", 40'({match_irq, match_wake}), 40'h0);
    pulses(64);
    rd_cnt(v); check("R6 reached match value", v, 40'hE1000);
    check("R6 outputs high on match", 40'({match_irq, match_wake}), 40'h3);
    wr(4'd0, 8'h42);
    check("R6 outputs gated off", 40'({match_irq, match_wake}), 40'h0);
    wr(4'd0, 8'h66);
    pulses(127);
    rd_cnt(v); check("R7 holds until next step", v, 40'hE1000);
    pulses(1);
    rd_cnt(v); check("R7 clear on match", v, 40'h0);
    check("R6 outputs low after clear", 40'({match_irq, match_wake}), 40'h0);
  endtask

  task automatic t_zero_match;
    logic [39:0] v;
    wr(4'd0, 8'h06);
    wr_match(40'h0);
    wr_cnt(40'h0);
    wr(4'd0, 8'h46); idle(3);
    pulses(64);
    rd_cnt(v); check("R7 zero match never clears", v, 40'd1);
  endtask

  task automatic t_wrap;
    logic [39:0] v;
    wr(4'd0, 8'h02);
    wr_match(40'd5);
    wr_cnt(40'hFF_FFFF_FFFF);
    wr(4'd0, 8'h42); idle(3);
    pulses(63);
    rd_cnt(v); check("R11 all ones held", v, 40'hFF_FFFF_FFFF);
    pulses(1);
    rd_cnt(v); check("R11 wraps to zero", v, 40'h0);
  endtask

  task automatic t_snapshot;
    logic [7:0] b;
    wr(4'd0, 8'h02);
    wr_cnt(40'hFF);
    wr(4'd0, 8'h42); idle(3);
    rd(4'd1, b); check("R10 live low byte", 40'(b), 40'hFF);
    pulses(64);
    rd(4'd2, b); check("R10 byte1 from snapshot", 40'(b), 40'h00);
    rd(4'd1, b); check("R10 new low byte", 40'(b), 40'h00);
    rd(4'd2, b); check("R10 byte1 after new snapshot", 40'(b), 40'h01);
  endtask

  task automatic t_soft_reset;
    logic [39:0] v;
    wr(4'd0, 8'hC2); idle(2);
    rd_cnt(v); check("R4 soft reset clears", v, 40'h0);
    wr(4'd0, 8'h42);
    pulses(64);
    rd_cnt(v); check("R4 two strobes swallowed", v, 40'h0);
    pulses(2);
    rd_cnt(v); check("R4 counts after release", v, 40'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; xtal_pulse = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_match_reg();
    t_passthru();
    t_prescale();
    t_hold();
    t_load();
    t_keep_bit();
    t_match();
    t_zero_match();
    t_wrap();
    t_snapshot();
    t_soft_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule